// File: doc/BRIEF.md
# Fixed-Point Complex Multiply with Rounding and Saturation

The unit multiplies two complex numbers in fixed point. Each operand word packs a two's-complement real part in its low half and a two's-complement imaginary part in its high half. The four cross products between the halves are formed at full precision. Each product can be doubled to give a fractional (Q15-style) result. The products are combined into the real and imaginary sums, and a half-LSB rounding bias is added. Each sum is then clamped to the signed double-width range, and only its upper half is kept. The two kept halves are packed into one result word.

The unit is meant for filter and transform datapaths that multiply by twiddle or coefficient values and need a rounded, non-wrapping, half-width result. By default it has one register stage. A sticky flag records that at least one half has clipped since the last reset. The half width is a parameter; the default is 16 bits.

Top module: `cplx_mul_round`

## Requirements
- R1: With HALF_W = 16 and bits [15:0] of an operand holding the real part and bits [31:16] the imaginary part, both two's complement, the real sum is ar*br - ai*bi and the imaginary sum is ar*bi + ai*br.
- R2: When `scale_en` is 1, every one of the four products is shifted left by one bit before the sums are formed; when 0, the products are used unshifted.
- R3: A rounding bias of 2^(HALF_W-1) (0x8000 by default) is added to each sum before the upper half is taken.
- R4: Each biased sum is clamped to [-2^(2*HALF_W-1), 2^(2*HALF_W-1)-1] with an exact decision, never wrapped. A clipped half therefore reads 0x7FFF or 0x8000.
- R5: The result holds bits [2*HALF_W-1:HALF_W] of the clamped real sum in its low half and those of the clamped imaginary sum in its high half.
- R6: With scaling on, a real product of -32768 by -32768 with zero imaginary parts gives a real half of 0x7FFF, not 0x8000.
- R7: With the default registered stage, `result` shows the value for the operands sampled at a rising edge just after that edge and holds it until the next edge. While `rst` is high, `result` is cleared to 0.
- R8: `sat_seen` rises at the same edge that registers a clipped result. It then stays high until `rst`, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| scale_en | input | 1 | Double each product before summing |
| op_a | input | 2*HALF_W | First complex operand {imag, real} |
| op_b | input | 2*HALF_W | Second complex operand {imag, real} |
| result | output | 2*HALF_W | Rounded, saturated product {imag, real} |
| sat_seen | output | 1 | Sticky flag: a half has clipped since reset |

## Verification
The assertions assume that `rst` is held high from time zero through at least one rising edge. They also assume that operands and `scale_en` change only away from the rising edge, so each edge samples one settled vector. The bench drives every input on the falling edge and asserts reset before its first check. An exhaustive sweep on a 4-bit-half instance reaches every clipping pattern of the adder and clamp. A directed sequence on the default instance covers the extreme-operand corner and the persistence of the sticky flag across non-clipping vectors.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
   // Output timing variant of the multiplier
   typedef enum logic {
      CMUL_COMB = 1'b0,
      CMUL_REG  = 1'b1
   } cmul_stage_e;
endpackage

// File: rtl/cmul_partial.sv
// Forms the four cross products between operand halves, each optionally doubled.
// Index k: bit 1 selects the half of op_a (0 real, 1 imag), bit 0 the half of op_b.
module cmul_partial #(
   parameter int HALF_W = 16
) (
   input  logic [2*HALF_W-1:0]    op_a,
   input  logic [2*HALF_W-1:0]    op_b,
   input  logic                   scale_en,
   output logic [3:0][2*HALF_W:0] prod
);
   localparam int WORD_W = 2 * HALF_W;
   localparam int PROD_W = WORD_W + 1;

   if (HALF_W < 2) begin : g_bad_width
      $error("cmul_partial: HALF_W must be at least 2");
   end

   for (genvar k = 0; k < 4; k++) begin : g_prod
      localparam bit A_IMAG = ((k / 2) == 1);
      localparam bit B_IMAG = ((k % 2) == 1);
      logic signed [HALF_W-1:0] x_half;
      logic signed [HALF_W-1:0] y_half;
      logic signed [WORD_W-1:0] raw;
      logic signed [PROD_W-1:0] ext;

      if (A_IMAG) begin : g_ai
         assign x_half = op_a[WORD_W-1:HALF_W];
      end else begin : g_ar
         assign x_half = op_a[HALF_W-1:0];
      end
      if (B_IMAG) begin : g_bi
         assign y_half = op_b[WORD_W-1:HALF_W];
      end else begin : g_br
         assign y_half = op_b[HALF_W-1:0];
      end

      assign raw     = x_half * y_half;
      assign ext     = {raw[WORD_W-1], raw};
      assign prod[k] = scale_en ? (ext <<< 1) : ext;
   end
endmodule

// File: rtl/cmul_merge.sv
// Combines two products, adds the rounding bias, clamps to the double-width range
// and returns the upper half of the clamped value.
module cmul_merge #(
   parameter int HALF_W   = 16,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic [2*HALF_W:0]   prod_x,
   input  logic [2*HALF_W:0]   prod_y,
   output logic [HALF_W-1:0]   half,
   output logic                clip
);
   localparam int WORD_W = 2 * HALF_W;
   localparam int PROD_W = WORD_W + 1;
   localparam int ACC_W  = PROD_W + 2;
   localparam int EXT_W  = ACC_W - PROD_W;
   localparam int TOP_W  = ACC_W - WORD_W + 1;

   localparam logic signed [ACC_W-1:0] RND_BIAS =
      {{(ACC_W-HALF_W){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] SAT_MAX =
      {{TOP_W{1'b0}}, {(WORD_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] SAT_MIN =
      {{TOP_W{1'b1}}, {(WORD_W-1){1'b0}}};
   localparam logic [WORD_W-1:0] CLAMP_HI = {1'b0, {(WORD_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] CLAMP_LO = {1'b1, {(WORD_W-1){1'b0}}};

   logic signed [ACC_W-1:0] lhs;
   logic signed [ACC_W-1:0] rhs;
   logic signed [ACC_W-1:0] mixed;
   logic signed [ACC_W-1:0] acc;
   logic                    over_hi;
   logic                    over_lo;
   logic [WORD_W-1:0]       clamped;

   assign lhs = {{EXT_W{prod_x[PROD_W-1]}}, prod_x};
   assign rhs = {{EXT_W{prod_y[PROD_W-1]}}, prod_y};

   if (SUBTRACT) begin : g_sub
      assign mixed = lhs - rhs;
   end else begin : g_add
      assign mixed = lhs + rhs;
   end

   assign acc     = mixed + RND_BIAS;
   assign over_hi = (acc > SAT_MAX);
   assign over_lo = (acc < SAT_MIN);

   always_comb begin
      if (over_hi)      clamped = CLAMP_HI;
      else if (over_lo) clamped = CLAMP_LO;
      else              clamped = acc[WORD_W-1:0];
   end

   assign half = clamped[WORD_W-1:HALF_W];
   assign clip = over_hi | over_lo;
endmodule

// File: rtl/cplx_mul_round.sv
module cplx_mul_round #(
   parameter int                   HALF_W = 16,
   parameter cmul_pkg::cmul_stage_e STAGE = cmul_pkg::CMUL_REG
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  scale_en,
   input  logic [2*HALF_W-1:0]   op_a,
   input  logic [2*HALF_W-1:0]   op_b,
   output logic [2*HALF_W-1:0]   result,
   output logic                  sat_seen
);
   localparam int WORD_W = 2 * HALF_W;
   localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};
   localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};

   if (HALF_W < 2) begin : g_bad_width
      $error("cplx_mul_round: HALF_W must be at least 2");
   end

   logic [3:0][WORD_W:0] prod;
   logic [HALF_W-1:0]    re_half;
   logic [HALF_W-1:0]    im_half;
   logic                 re_clip;
   logic                 im_clip;
   logic                 clip_now;
   logic [WORD_W-1:0]    comb_word;
   logic                 sat_q;

   cmul_partial #(.HALF_W(HALF_W)) u_partial (
      .op_a     (op_a),
      .op_b     (op_b),
      .scale_en (scale_en),
      .prod     (prod)
   );

   // real: ar*br - ai*bi  (indices 0 and 3)
   cmul_merge #(.HALF_W(HALF_W), .SUBTRACT(1'b1)) u_merge_re (
      .prod_x (prod[0]),
      .prod_y (prod[3]),
      .half   (re_half),
      .clip   (re_clip)
   );

   // imaginary: ar*bi + ai*br  (indices 1 and 2)
   cmul_merge #(.HALF_W(HALF_W), .SUBTRACT(1'b0)) u_merge_im (
      .prod_x (prod[1]),
      .prod_y (prod[2]),
      .half   (im_half),
      .clip   (im_clip)
   );

   assign comb_word = {im_half, re_half};
   assign clip_now  = re_clip | im_clip;

   if (STAGE == cmul_pkg::CMUL_REG) begin : g_reg
      logic [WORD_W-1:0] result_q;
      always_ff @(posedge clk) begin
         if (rst) result_q <= '0;
         else     result_q <= comb_word;
      end
      assign result = result_q;

      // R7: registered word equals the datapath value of the previous edge
      p_reg_stage_r7: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (result == $past(comb_word)));

      // R7: reset empties the output stage
      p_reset_clear_r7: assert property (@(posedge clk)
         rst |=> (result == '0));
   end else begin : g_comb
      assign result = comb_word;
   end

   always_ff @(posedge clk) begin
      if (rst) sat_q <= 1'b0;
      else     sat_q <= sat_q | clip_now;
   end
   assign sat_seen = sat_q;

   // R4: a clipped real half is pinned to an extreme code
   p_clip_pin_re_r4: assert property (@(posedge clk) disable iff (rst)
      re_clip |-> (re_half == HALF_MAX || re_half == HALF_MIN));

   // R4: a clipped imaginary half is pinned to an extreme code
   p_clip_pin_im_r4: assert property (@(posedge clk) disable iff (rst)
      im_clip |-> (im_half == HALF_MAX || im_half == HALF_MIN));

   // R8: a clip raises the sticky flag at the next edge
   p_sticky_set_r8: assert property (@(posedge clk) disable iff (rst)
      clip_now |=> sat_seen);

   // R8: the sticky flag never drops outside reset
   p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
      sat_seen |=> sat_seen);

   // R8: reset clears the sticky flag
   p_sticky_reset_r8: assert property (@(posedge clk)
      rst |=> !sat_seen);
endmodule

// File: tb/cplx_mul_round_test.sv
module cplx_mul_round_test;
   localparam int CLK_PERIOD = 10;
   localparam int BIG_W      = 16;
   localparam int SMALL_W    = 4;
   localparam int WATCHDOG   = 190000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic                  scale_b = 1'b0;
   logic [2*BIG_W-1:0]    a_b = '0;
   logic [2*BIG_W-1:0]    b_b = '0;
   logic [2*BIG_W-1:0]    res_b;
   logic                  sat_b;

   logic                  scale_s = 1'b0;
   logic [2*SMALL_W-1:0]  a_s = '0;
   logic [2*SMALL_W-1:0]  b_s = '0;
   logic [2*SMALL_W-1:0]  res_s;
   logic                  sat_s;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   cplx_mul_round #(.HALF_W(BIG_W)) uut (
      .clk(clk), .rst(rst), .scale_en(scale_b),
      .op_a(a_b), .op_b(b_b), .result(res_b), .sat_seen(sat_b)
   );

   cplx_mul_round #(.HALF_W(SMALL_W)) uut_small (
      .clk(clk), .rst(rst), .scale_en(scale_s),
      .op_a(a_s), .op_b(b_s), .result(res_s), .sat_seen(sat_s)
   );

   function automatic longint sx(longint v, int w);
      return (v >= (longint'(1) << (w-1))) ? v - (longint'(1) << w) : v;
   endfunction

   function automatic longint clampv(longint v, int w, ref bit clip);
      longint hi = (longint'(1) << (2*w-1)) - 1;
      longint lo = -(longint'(1) << (2*w-1));
      if (v > hi) begin clip = 1'b1; return hi; end
      if (v < lo) begin clip = 1'b1; return lo; end
      return v;
   endfunction

   // Arithmetic reference from the requirements (R1..R5)
   function automatic void model(input int w, input longint aw, input longint bw,
                                 input bit sc, output longint res, output bit clip);
      longint m  = (longint'(1) << w) - 1;
      longint ar = sx(aw & m, w);
      longint ai = sx((aw >> w) & m, w);
      longint br = sx(bw & m, w);
      longint bi = sx((bw >> w) & m, w);
      longint k  = sc ? 2 : 1;
      longint rb = longint'(1) << (w-1);
      longint re, im;
      clip = 1'b0;
      re  = clampv(k*ar*br - k*ai*bi + rb, w, clip);
      im  = clampv(k*ar*bi + k*ai*br + rb, w, clip);
      res = (((im >>> w) & m) << w) | ((re >>> w) & m);
   endfunction

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic big_step(logic [31:0] a, logic [31:0] b, logic sc);
      @(negedge clk);
      a_b = a; b_b = b; scale_b = sc;
      @(posedge clk);
      #1;
   endtask

   task automatic big_expect(string req, logic [31:0] a, logic [31:0] b, logic sc);
      longint r; bit c;
      model(BIG_W, longint'(a), longint'(b), sc, r, c);
      big_step(a, b, sc);
      check(req, longint'(res_b), r);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      longint r;
      bit     c;
      bit     exp_sticky;

      // Reset state (R7, R8)
      repeat (3) @(posedge clk);
      #1;
      check("R7 reset result", longint'(res_b), 0);
      check("R8 reset sticky", longint'(sat_b), 0);
      check("R7 reset result small", longint'(res_s), 0);
      @(negedge clk);
      rst = 1'b0;

      // R1/R5: 0.5*0.5 in Q15 unscaled -> real 0x1000
      big_step(32'h0000_4000, 32'h0000_4000, 1'b0);
      check("R1 R5 real-only product", longint'(res_b), 64'h0000_1000);
      // R1: mixed signs, both halves
      big_expect("R1 mixed signs", 32'hC123_3A5B, 32'h7F01_9ABC, 1'b0);
      big_expect("R1 R5 imag terms", 32'h1234_0000, 32'h0000_5678, 1'b0);
      // R2: scale doubles the products
      big_expect("R2 scale off", 32'h2000_3000, 32'hE000_1800, 1'b0);
      big_expect("R2 scale on", 32'h2000_3000, 32'hE000_1800, 1'b1);
      // R3: product 0x8000 rounds up to real half 1
      big_step(32'h0000_0100, 32'h0000_0080, 1'b0);
      check("R3 rounding bias", longint'(res_b), 64'h0000_0001);
      check("R8 no clip yet", longint'(sat_b), 0);

      // R7: output holds between edges
      @(negedge clk);
      a_b = 32'h0100_0100; b_b = 32'h0200_0300;
      #1;
      check("R7 hold before edge", longint'(res_b), 64'h0000_0001);
      @(posedge clk);
      #1;
      model(BIG_W, 64'h0100_0100, 64'h0200_0300, 1'b0, r, c);
      check("R7 update after edge", longint'(res_b), r);

      // R6: -32768 * -32768 with scale clamps to 0x7FFF
      big_step(32'h0000_8000, 32'h0000_8000, 1'b1);
      check("R6 extreme product", longint'(res_b), 64'h0000_7FFF);
      check("R8 sticky set", longint'(sat_b), 1);
      // R4: negative clip on real, imag small
      big_step(32'h8000_8000, 32'h8000_7FFF, 1'b1);
      check("R4 negative clip", longint'(res_b), 64'h0001_8000);
      // R8: sticky survives non-clipping vector
      big_expect("R8 plain after clip", 32'h0010_0020, 32'h0030_0040, 1'b0);
      check("R8 sticky holds", longint'(sat_b), 1);

      // R8: reset clears sticky
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check("R8 sticky cleared", longint'(sat_b), 0);
      check("R7 result cleared", longint'(res_b), 0);
      @(negedge clk);
      rst = 1'b0;

      // Exhaustive sweep on the 4-bit-half instance (R1..R5, R8)
      exp_sticky = 1'b0;
      for (int s = 0; s < 2; s++) begin
         for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
               @(negedge clk);
               a_s = 8'(a); b_s = 8'(b); scale_s = s[0];
               @(posedge clk);
               #1;
               model(SMALL_W, longint'(a), longint'(b), s[0], r, c);
               exp_sticky = exp_sticky | c;
               check("R1 R2 R3 R4 R5 sweep", longint'(res_s), r);
               check("R8 sweep sticky", longint'(sat_s), longint'(exp_sticky));
            end
         end
      end

      finish_run();
   end
endmodule